// File: doc/BRIEF.md
# Seven-to-One Display Lane Serializer

This block turns a 21-bit parallel pixel word into three serial data lanes plus one framing-clock lane. The word holds eighteen colour bits (six each for red, green and blue) and three timing bits: line sync, frame sync and data-enable. The whole design runs on a fast bit clock at seven times the pixel rate. The pixel clock arrives as a plain input that the bit clock samples. One word is captured per pixel period. Each lane then sends seven bits of it during the next seven bit clocks, so one pixel period fills one frame on every lane.

A strobe-select input picks which pixel-clock edge captures the word. An activity monitor counts bit clocks since the last pixel-clock transition. When that count reaches its limit, it mutes every lane to logic low. An active-low power-down input clears all internal state and drops the pad drive enable, so an external pad ring can float the lanes. Power-down, pixel clock and data may start or stop in any order.

Top module: `dl_serializer7`

## Requirements
- R1: On each selected pixel-clock edge the whole 21-bit word is taken at once. It is sent in full in the frame that starts at the next frame boundary.
- R2: Lane L in slot S (S = 0..6, one slot per bit clock, slot 0 first) carries word bit 7*L+S. Bits [5:0] are red, [11:6] green, [17:12] blue, bit 18 line sync, bit 19 frame sync and bit 20 data-enable.
- R3: The clock lane sends 1,1,1,1,0,0,0 in slots 0..6, aligned to the data-lane frames.
- R4: With the strobe select at 1 the word is taken on the pixel clock's rising edge. With it at 0 the word is taken on the falling edge.
- R5: After 16 consecutive bit clocks with no pixel-clock transition, every lane, including the clock lane, is driven to 0.
- R6: After the pixel clock returns, lanes stay low until the first frame loaded from a freshly captured word. Normal output resumes from that frame's slot 0.
- R7: While power-down is low, the drive enable is 0 and all lanes are 0, and the block is held in reset. After release, lanes stay low until a word has been captured and a full frame begins. This holds whether the pixel clock starts before or after release.
- R8: A change of the input word between captures does not alter the frame being sent.
- R9: During reset all lanes are 0, and the drive enable follows the power-down input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast bit clock, seven times the pixel rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pd_ni | input | 1 | Active-low power-down; low clears state and disables pad drive |
| pclk_i | input | 1 | Pixel clock, sampled by clk_i |
| rise_sel_i | input | 1 | 1: capture on rising pixel-clock edge; 0: falling |
| pix_i | input | 21 | Pixel word: colour bits and line sync, frame sync, data-enable |
| lane_o | output | 3 | Serial data lanes |
| clk_lane_o | output | 1 | Framing clock lane |
| drive_en_o | output | 1 | Pad drive enable; 0 asks the pads to float |

## Verification
The bench drives the pixel word twice per pixel period, once between the two pixel-clock edges and once just before the wrap. As a result, an edge-select mistake captures a visibly different word. Pixel-clock gaps longer than the loss limit must mute the lanes. A design that never muted would keep repeating its last frame, and one that unmuted early would emit a stale or half frame before the first fresh capture. Power-down is exercised with the pixel clock running and with it stopped and restarted after release. A block that kept state through power-down, or drove the lanes before a fresh frame, would show nonzero lane bits where the reference expects zeros. Lane and slot mapping faults and a wrong clock-lane pattern appear as mismatches in the per-cycle comparison under walking-one, alternating and pseudo-random words.

// File: rtl/dl_ser_pkg.sv
package dl_ser_pkg;
    localparam int LANES      = 3;
    localparam int SLOTS      = 7;
    localparam int WORD_W     = LANES * SLOTS;
    localparam int CLK_HIGH   = 4;
    localparam int LOSS_LIMIT = 16;
endpackage

// File: rtl/dl_pclk_mon.sv
module dl_pclk_mon #(
    parameter int LOSS_LIMIT = dl_ser_pkg::LOSS_LIMIT
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic pclk_i,
    input  logic rise_sel_i,
    output logic cap_o,
    output logic lost_o
);
    localparam int CW = $clog2(LOSS_LIMIT + 1);

    typedef struct packed {
        logic          pclk;
        logic [CW-1:0] idle;
        logic          lost;
    } mon_t;

    mon_t st_d, st_q;
    logic trans;

    always_comb begin
        st_d  = st_q;
        trans = pclk_i ^ st_q.pclk;
        cap_o = rise_sel_i ? (pclk_i & ~st_q.pclk) : (~pclk_i & st_q.pclk);
        st_d.pclk = pclk_i;
        if (trans)
            st_d.idle = '0;
        else if (st_q.idle != CW'(LOSS_LIMIT))
            st_d.idle = st_q.idle + 1'b1;
        st_d.lost = (st_d.idle == CW'(LOSS_LIMIT));
        if (clr_i)
            st_d = '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign lost_o = st_q.lost;

    // R5: any pixel-clock transition clears the loss flag next cycle
    a_r5_activity_clears_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i && (pclk_i != st_q.pclk)) |=> !st_q.lost);
endmodule

// File: rtl/dl_word_hold.sv
module dl_word_hold #(
    parameter int WORD_W = dl_ser_pkg::WORD_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              cap_i,
    input  logic              load_i,
    input  logic              lost_i,
    input  logic [WORD_W-1:0] pix_i,
    output logic [WORD_W-1:0] hold_o,
    output logic              mute_o
);
    typedef struct packed {
        logic [WORD_W-1:0] hold;
        logic              fresh;
        logic              mute;
    } hold_t;

    localparam hold_t RESET_ST = '{hold: '0, fresh: 1'b0, mute: 1'b1};

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap_i) begin
            st_d.hold  = pix_i;
            st_d.fresh = 1'b1;
        end else if (load_i) begin
            st_d.fresh = 1'b0;
        end
        if (lost_i)
            st_d.mute = 1'b1;
        else if (load_i && st_q.fresh)
            st_d.mute = 1'b0;
        if (clr_i)
            st_d = RESET_ST;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= RESET_ST;
        else         st_q <= st_d;
    end

    assign hold_o = st_q.hold;
    assign mute_o = st_q.mute;

    // R8: the holding word only changes on a capture
    a_r8_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i && !cap_i) |=> $stable(st_q.hold));

    // R6: unmuting only happens at a frame load of a fresh word
    a_r6_unmute_on_fresh_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(st_q.mute) |-> ($past(load_i) && $past(st_q.fresh)));
endmodule

// File: rtl/dl_lane_shift.sv
module dl_lane_shift #(
    parameter int LANES    = dl_ser_pkg::LANES,
    parameter int SLOTS    = dl_ser_pkg::SLOTS,
    parameter int CLK_HIGH = dl_ser_pkg::CLK_HIGH,
    localparam int WORD_W  = LANES * SLOTS
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic [WORD_W-1:0] frame_i,
    input  logic              mute_i,
    output logic              load_o,
    output logic [LANES-1:0]  lane_o,
    output logic              clk_lane_o
);
    localparam int SW = $clog2(SLOTS);

    typedef struct packed {
        logic [SW-1:0]                  slot;
        logic [LANES-1:0][SLOTS-1:0]    shift;
    } sh_t;

    sh_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        load_o = (st_q.slot == SW'(SLOTS - 1));
        if (load_o) begin
            st_d.slot = '0;
            for (int l = 0; l < LANES; l++)
                st_d.shift[l] = frame_i[l*SLOTS +: SLOTS];
        end else begin
            st_d.slot = st_q.slot + 1'b1;
            for (int l = 0; l < LANES; l++)
                st_d.shift[l] = st_q.shift[l] >> 1;
        end
        if (clr_i)
            st_d = '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign clk_lane_o = ~mute_i & (st_q.slot < SW'(CLK_HIGH));

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_o[l] = ~mute_i & st_q.shift[l][0];

        // R2: between loads each lane advances by one slot, lowest bit first
        a_r2_lane_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!clr_i && (st_q.slot != SW'(SLOTS - 1))) |=>
                (st_q.shift[l] == ($past(st_q.shift[l]) >> 1)));
    end

    // R3: the slot count wraps to zero after the last slot
    a_r3_slot_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.slot == SW'(SLOTS - 1)) |=> (st_q.slot == '0));
endmodule

// File: rtl/dl_serializer7.sv
module dl_serializer7 #(
    parameter int LANES      = dl_ser_pkg::LANES,
    parameter int SLOTS      = dl_ser_pkg::SLOTS,
    parameter int CLK_HIGH   = dl_ser_pkg::CLK_HIGH,
    parameter int LOSS_LIMIT = dl_ser_pkg::LOSS_LIMIT,
    localparam int WORD_W    = LANES * SLOTS
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              pd_ni,
    input  logic              pclk_i,
    input  logic              rise_sel_i,
    input  logic [WORD_W-1:0] pix_i,
    output logic [LANES-1:0]  lane_o,
    output logic              clk_lane_o,
    output logic              drive_en_o
);
    logic              clr, cap, lost, load, mute, clk_lane_int;
    logic [WORD_W-1:0] hold;
    logic [LANES-1:0]  lane_int;

    assign clr = ~pd_ni;

    dl_pclk_mon #(.LOSS_LIMIT(LOSS_LIMIT)) mon_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .pclk_i(pclk_i),
        .rise_sel_i(rise_sel_i), .cap_o(cap), .lost_o(lost));

    dl_word_hold #(.WORD_W(WORD_W)) hold_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .cap_i(cap), .load_i(load),
        .lost_i(lost), .pix_i(pix_i), .hold_o(hold), .mute_o(mute));

    dl_lane_shift #(.LANES(LANES), .SLOTS(SLOTS), .CLK_HIGH(CLK_HIGH)) shift_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .frame_i(hold), .mute_i(mute),
        .load_o(load), .lane_o(lane_int), .clk_lane_o(clk_lane_int));

    assign drive_en_o = pd_ni;
    assign lane_o     = pd_ni ? lane_int : '0;
    assign clk_lane_o = pd_ni & clk_lane_int;

    // R7: power-down silences every lane and drops the drive enable
    a_r7_pd_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pd_ni |-> (lane_o == '0 && !clk_lane_o && !drive_en_o));
endmodule

// File: tb/dl_serializer7_tb_top.sv
module dl_serializer7_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pd_n = 1'b1;
    logic        pclk = 1'b0;
    logic        rise = 1'b0;
    logic [20:0] pix = '0;
    logic [2:0]  lane;
    logic        clk_lane, drv_en;

    int    checks = 0, errs = 0;
    string cur_req = "R9";
    bit    run_pclk = 1'b0;
    int    ph = 0;
    int    pat_k = 0;
    logic [20:0] lfsr = 21'h1B3C5;
    bit    done = 1'b0;

    always #10 clk = ~clk;

    dl_serializer7 dut_i (
        .clk_i(clk), .rst_ni(rst_n), .pd_ni(pd_n), .pclk_i(pclk),
        .rise_sel_i(rise), .pix_i(pix), .lane_o(lane), .clk_lane_o(clk_lane),
        .drive_en_o(drv_en));

    // reference model state
    bit          m_prev, m_fresh, m_mute, m_lost;
    int          m_idle, m_slot;
    logic [20:0] m_hold, m_frame;

    always @(posedge clk) begin
        if (!rst_n || !pd_n) begin
            m_prev = 0; m_fresh = 0; m_mute = 1; m_lost = 0;
            m_idle = 0; m_slot = 0; m_hold = '0; m_frame = '0;
        end else begin
            bit tr, sel, ld, nmute;
            int nidle;
            tr  = (pclk != m_prev);
            sel = rise ? (pclk && !m_prev) : (!pclk && m_prev);
            ld  = (m_slot == 6);
            nidle = tr ? 0 : ((m_idle >= 16) ? 16 : m_idle + 1);
            nmute = m_lost ? 1'b1 : ((ld && m_fresh) ? 1'b0 : m_mute);
            if (ld) m_frame = m_hold;
            m_slot = ld ? 0 : m_slot + 1;
            if (sel) begin m_hold = pix; m_fresh = 1; end
            else if (ld) m_fresh = 0;
            m_lost = (nidle >= 16);
            m_idle = nidle;
            m_prev = pclk;
            m_mute = nmute;
        end
    end

    function automatic logic [4:0] expected();
        logic [4:0] e;
        e = '0;
        e[4] = pd_n;
        if (pd_n && !m_mute) begin
            e[3] = (m_slot < 4);
            for (int l = 0; l < 3; l++) e[l] = m_frame[7*l + m_slot];
        end
        return e;
    endfunction

    function automatic logic [20:0] next_pattern();
        pat_k++;
        lfsr = {lfsr[19:0], lfsr[20] ^ lfsr[18]};
        case (pat_k % 4)
            0: return lfsr;
            1: return 21'h1FFFFF;
            2: return (pat_k % 8 == 2) ? 21'h0AAAAA : 21'h155555;
            default: return 21'(1) << (pat_k % 21);
        endcase
    endfunction

    task automatic check(string req, logic [4:0] act, logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%b expected=%b (en,clk,lane2..0)", req, act, exp);
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(cur_req, {drv_en, clk_lane, lane}, expected());
            if (run_pclk) begin
                ph = (ph + 1) % 7;
                pclk = (ph < 4);
                if (ph == 2 || ph == 5) pix = next_pattern();
            end
        end
    endtask

    initial begin
        // R9: reset state
        cur_req = "R9";
        step(5);
        rst_n = 1'b1;
        run_pclk = 1'b1;
        // R1/R2/R3/R8 with falling-edge capture
        cur_req = "R1"; step(70);
        cur_req = "R2"; step(70);
        cur_req = "R3"; step(35);
        cur_req = "R8"; step(35);
        // R4: rising-edge capture
        rise = 1'b1;
        cur_req = "R4"; step(84);
        // R5: pixel clock stops
        run_pclk = 1'b0;
        cur_req = "R5"; step(30);
        @(negedge clk);
        check("R5", {clk_lane, lane}, 4'b0000);
        // R6: pixel clock returns
        run_pclk = 1'b1;
        cur_req = "R6"; step(50);
        // R7: power-down with clock running
        pd_n = 1'b0;
        cur_req = "R7"; step(10);
        @(negedge clk);
        check("R7", {drv_en, clk_lane, lane}, 5'b00000);
        pd_n = 1'b1;
        step(42);
        // R7: power-down, clock stopped, released, clock started later
        pd_n = 1'b0; run_pclk = 1'b0;
        step(8);
        pd_n = 1'b1;
        step(20);
        rise = 1'b0;
        run_pclk = 1'b1;
        step(49);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule